// File: doc/BRIEF.md
# Congestion-Switched XY / Odd-Even Route Selector

This block is the route computation stage of one mesh router. It watches how full its own four input buffers are. When any of them reaches a programmable level it raises a registered congestion flag towards the neighbouring routers. It also takes in the four flags that those neighbours drive back.

For every packet request, the block looks at the router's own coordinates, the destination coordinates and the input port the packet came in on. One cycle later it returns a one-hot output port. While every neighbour flag is low it routes in plain dimension order: X first, then Y. As soon as any single neighbour flag is high it routes adaptively. In that mode it uses only the minimal directions that the column-parity turn rules permit, and it prefers a direction whose neighbour is not congested.

Coordinates grow eastward in X and southward in Y.

Top module: `dmr_route_top`

## Requirements
- R1: `cong_flag` is high in the cycle after any buffer depth was greater than or equal to `thresh`. It is low in the cycle after every depth was below `thresh`, so a change at the inputs shows up one clock later. With `thresh` equal to 0 the flag is always set after reset. The buffers sit in `buf_depth` in 4-bit slices, east in bits 3:0, then west, north and south.
- R2: While `rst_n` is low at a clock edge, the block clears `cong_flag`, `route_valid` and `route_port` to 0.
- R3: `route_valid` repeats `req_valid` one clock later, and `route_port` carries the answer to the request sampled at that edge. `route_port` is one-hot when valid, with bit 0 Local, bit 1 East, bit 2 West, bit 3 North and bit 4 South. It is all zero when not valid.
- R4: The block uses adaptive routing for a request when at least one bit of `nbr_flag` is high in that cycle, and deterministic routing otherwise. The flag bits are 0 east, 1 west, 2 north and 3 south.
- R5: In deterministic mode the block picks East if `dest_x` > `my_x` and West if `dest_x` < `my_x`. Otherwise it picks South if `dest_y` > `my_y`, North if `dest_y` < `my_y`, and Local if both coordinates match.
- R6: In both modes a destination equal to the router's own position yields Local.
- R7: In adaptive mode, when `my_x` is odd, a packet that entered on the North port (`req_src`=3) or the South port (`req_src`=4) never leaves West, provided another minimal port exists.
- R8: In adaptive mode, when `my_x` is even, a packet that entered on the West port (`req_src`=2) never leaves North or South, provided another minimal port exists. `req_src` 0 is Local, 1 East, and the codes 5 to 7 count as Local.
- R9: In adaptive mode, when both the X and the Y minimal ports are legal, the block picks the Y port only if the X neighbour's flag is set and the Y neighbour's flag is clear. In every other case it picks the X port.
- R10: In adaptive mode, when exactly one minimal port is legal the block picks that port. When the turn rules leave none, it falls back to the deterministic port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| my_x | input | X_W | Column of this router |
| my_y | input | Y_W | Row of this router |
| thresh | input | DEPTH_W | Congestion level, compared with each buffer depth |
| buf_depth | input | NUM_BUF*DEPTH_W | Packed fill counts of the input buffers |
| nbr_flag | input | 4 | Congestion flags from the east, west, north and south neighbours |
| req_valid | input | 1 | Route request strobe |
| req_src | input | 3 | Input port the packet arrived on |
| dest_x | input | X_W | Destination column |
| dest_y | input | Y_W | Destination row |
| cong_flag | output | 1 | Registered congestion flag to the neighbours |
| route_valid | output | 1 | Route result valid |
| route_port | output | 5 | One-hot output port |

## Verification
The routing sweep covers every pairing of destination and router column on two rows, for all five input ports and all sixteen neighbour-flag patterns. An all-low flag pattern isolates the dimension-order path. Patterns with one flag high tell apart the turn-rule pruning from the congestion preference. Patterns with both candidate flags high confirm the X-favouring tie. Column parity decides which ban applies, and arrivals from the North, South and West ports are the only ones that reach a ban.

The congestion sweep raises one buffer at a time through every depth against every threshold. It separates an at-threshold depth from a below-threshold depth, it covers a threshold of zero, and it shows that the flag lags its inputs by exactly one edge.

// File: rtl/dmr_pkg.sv
// Shared constants for the dual-mode route selector.
// Assumes a 2-D mesh with X growing east and Y growing south.
package dmr_pkg;
    // one-hot output port bit positions
    localparam int P_LOC   = 0;
    localparam int P_EAST  = 1;
    localparam int P_WEST  = 2;
    localparam int P_NORTH = 3;
    localparam int P_SOUTH = 4;
    localparam int NUM_OUT = 5;
    localparam int NUM_DIR = 4;

    // input port codes carried on req_src
    typedef enum logic [2:0] {
        SRC_LOC   = 3'd0,
        SRC_EAST  = 3'd1,
        SRC_WEST  = 3'd2,
        SRC_NORTH = 3'd3,
        SRC_SOUTH = 3'd4
    } src_e;

    typedef logic [NUM_OUT-1:0] port_t;
endpackage

// File: rtl/dmr_cong_mon.sv
// Congestion monitor: compares each input buffer depth against a shared
// threshold and registers the OR of the hits as the outgoing flag.
// Assumes depths are packed buffer 0 in the low slice.
module dmr_cong_mon #(
    parameter int NUM_BUF = 4,
    parameter int DEPTH_W = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [DEPTH_W-1:0]         thresh,
    input  logic [NUM_BUF*DEPTH_W-1:0] depth_flat,
    output logic                       flag_q
);
    logic [NUM_BUF-1:0] hit;

    // per-buffer threshold comparators
    genvar gi;
    generate
        for (gi = 0; gi < NUM_BUF; gi++) begin : g_cmp
            assign hit[gi] = (depth_flat[gi*DEPTH_W +: DEPTH_W] >= thresh);

            // R1
            buf_hit_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(depth_flat[gi*DEPTH_W +: DEPTH_W] >= thresh)) |-> flag_q);
        end
    endgenerate

    // register the combined congestion indication
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= |hit;
    end

    // R1
    zero_thresh_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(thresh) == '0) |-> flag_q);
endmodule

// File: rtl/dmr_xy_calc.sv
// Dimension-order port computation plus the set of minimal directions.
// Pure combinational; X is resolved before Y.
module dmr_xy_calc
    import dmr_pkg::*;
#(
    parameter int X_W = 3,
    parameter int Y_W = 3
) (
    input  logic [X_W-1:0] my_x,
    input  logic [Y_W-1:0] my_y,
    input  logic [X_W-1:0] dest_x,
    input  logic [Y_W-1:0] dest_y,
    output port_t          xy_port,
    output port_t          min_ports
);
    logic go_e, go_w, go_n, go_s;

    // coordinate comparisons
    always_comb begin
        go_e = dest_x > my_x;
        go_w = dest_x < my_x;
        go_s = dest_y > my_y;
        go_n = dest_y < my_y;
    end

    // minimal direction set, Local only when already home
    always_comb begin
        min_ports          = '0;
        min_ports[P_EAST]  = go_e;
        min_ports[P_WEST]  = go_w;
        min_ports[P_NORTH] = go_n;
        min_ports[P_SOUTH] = go_s;
        min_ports[P_LOC]   = !(go_e || go_w || go_n || go_s);
    end

    // X-then-Y deterministic choice
    always_comb begin
        xy_port = '0;
        if (go_e)      xy_port[P_EAST]  = 1'b1;
        else if (go_w) xy_port[P_WEST]  = 1'b1;
        else if (go_s) xy_port[P_SOUTH] = 1'b1;
        else if (go_n) xy_port[P_NORTH] = 1'b1;
        else           xy_port[P_LOC]   = 1'b1;
    end
endmodule

// File: rtl/dmr_oe_sel.sv
// Adaptive port selection under column-parity turn bans.
// Odd column: no turn from northbound/southbound travel to West.
// Even column: no turn from eastbound travel to North or South.
// Among two legal ports an uncongested Y port beats a congested X port;
// otherwise X wins. With nothing legal the XY port is used.
module dmr_oe_sel
    import dmr_pkg::*;
(
    input  logic               col_odd,
    input  logic [2:0]         src,
    input  port_t              min_ports,
    input  port_t              xy_port,
    input  logic [NUM_DIR-1:0] nbr_flag,
    output port_t              oe_port
);
    port_t ban, legal, x_leg, y_leg;
    logic  trav_vert, trav_east, x_cong, y_cong;

    // travel direction decoded from the arrival port
    always_comb begin
        trav_vert = (src == SRC_NORTH) || (src == SRC_SOUTH);
        trav_east = (src == SRC_WEST);
    end

    // turn bans for this column parity
    always_comb begin
        ban = '0;
        if (col_odd && trav_vert) ban[P_WEST] = 1'b1;
        if (!col_odd && trav_east) begin
            ban[P_NORTH] = 1'b1;
            ban[P_SOUTH] = 1'b1;
        end
    end

    // legal minimal ports split by dimension
    always_comb begin
        legal = min_ports & ~ban;
        x_leg = legal & ((port_t'(1) << P_EAST) | (port_t'(1) << P_WEST));
        y_leg = legal & ((port_t'(1) << P_NORTH) | (port_t'(1) << P_SOUTH));
        x_cong = |(x_leg[NUM_OUT-1:1] & nbr_flag);
        y_cong = |(y_leg[NUM_OUT-1:1] & nbr_flag);
    end

    // final adaptive pick
    always_comb begin
        if (legal == '0)             oe_port = xy_port;
        else if (legal[P_LOC])       oe_port = legal;
        else if (x_leg == '0)        oe_port = y_leg;
        else if (y_leg == '0)        oe_port = x_leg;
        else if (x_cong && !y_cong)  oe_port = y_leg;
        else                         oe_port = x_leg;
    end
endmodule

// File: rtl/dmr_route_top.sv
// Per-router route selector. Raises a registered congestion flag from its
// own buffer depths and, per request, returns a registered one-hot port:
// XY while all neighbour flags are low, Odd-Even adaptive otherwise.
// Assumes one request per cycle at most and a synchronous active-low reset.
module dmr_route_top
    import dmr_pkg::*;
#(
    parameter int X_W     = 3,
    parameter int Y_W     = 3,
    parameter int DEPTH_W = 4,
    parameter int NUM_BUF = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [X_W-1:0]             my_x,
    input  logic [Y_W-1:0]             my_y,
    input  logic [DEPTH_W-1:0]         thresh,
    input  logic [NUM_BUF*DEPTH_W-1:0] buf_depth,
    input  logic [3:0]                 nbr_flag,
    input  logic                       req_valid,
    input  logic [2:0]                 req_src,
    input  logic [X_W-1:0]             dest_x,
    input  logic [Y_W-1:0]             dest_y,
    output logic                       cong_flag,
    output logic                       route_valid,
    output logic [4:0]                 route_port
);
    port_t xy_port, min_ports, oe_port, next_port;
    logic  adaptive;

    dmr_cong_mon #(.NUM_BUF(NUM_BUF), .DEPTH_W(DEPTH_W)) u_cong (
        .clk(clk), .rst_n(rst_n), .thresh(thresh),
        .depth_flat(buf_depth), .flag_q(cong_flag)
    );

    dmr_xy_calc #(.X_W(X_W), .Y_W(Y_W)) u_xy (
        .my_x(my_x), .my_y(my_y), .dest_x(dest_x), .dest_y(dest_y),
        .xy_port(xy_port), .min_ports(min_ports)
    );

    dmr_oe_sel u_oe (
        .col_odd(my_x[0]), .src(req_src), .min_ports(min_ports),
        .xy_port(xy_port), .nbr_flag(nbr_flag), .oe_port(oe_port)
    );

    // mode pick: any neighbour flag forces adaptive routing
    always_comb begin
        adaptive  = |nbr_flag;
        next_port = adaptive ? oe_port : xy_port;
    end

    // result register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            route_valid <= 1'b0;
            route_port  <= '0;
        end else begin
            route_valid <= req_valid;
            route_port  <= req_valid ? next_port : '0;
        end
    end

    // R3
    onehot_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        route_valid |-> $onehot(route_port));
    // R3
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !route_valid |-> (route_port == '0));
    // R3
    valid_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (route_valid == $past(req_valid)));
    // R5
    det_east_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && req_valid && nbr_flag == 4'd0 && dest_x > my_x)
        |-> route_port[P_EAST]);
    // R6
    home_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && req_valid && dest_x == my_x && dest_y == my_y)
        |-> route_port[P_LOC]);
    // R7
    odd_no_west_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && req_valid && nbr_flag != 4'd0 && my_x[0]
              && (req_src == SRC_NORTH || req_src == SRC_SOUTH)
              && dest_x < my_x && dest_y != my_y)
        |-> !route_port[P_WEST]);
    // R8
    even_no_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && req_valid && nbr_flag != 4'd0 && !my_x[0]
              && req_src == SRC_WEST && dest_x != my_x)
        |-> !(route_port[P_NORTH] || route_port[P_SOUTH]));
endmodule

// File: tb/sim_dmr_route_top.sv
// Sweep bench for the dual-mode route selector.
module sim_dmr_route_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  my_x = '0, my_y = '0, dest_x = '0, dest_y = '0;
    logic [3:0]  thresh = 4'd8;
    logic [15:0] buf_depth = '0;
    logic [3:0]  nbr_flag = '0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_src = '0;
    logic        cong_flag, route_valid;
    logic [4:0]  route_port;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dmr_route_top u0 (
        .clk(clk), .rst_n(rst_n), .my_x(my_x), .my_y(my_y), .thresh(thresh),
        .buf_depth(buf_depth), .nbr_flag(nbr_flag), .req_valid(req_valid),
        .req_src(req_src), .dest_x(dest_x), .dest_y(dest_y),
        .cong_flag(cong_flag), .route_valid(route_valid), .route_port(route_port)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // expected port from the requirements: L=1 E=2 W=4 N=8 S=16
    function automatic int exp_route(int mx, int my, int dx, int dy, int src, int f);
        int xy, xp, yp, fx, fy;
        bit okx, oky;
        if (dx > mx) xy = 2;
        else if (dx < mx) xy = 4;
        else if (dy > my) xy = 16;
        else if (dy < my) xy = 8;
        else xy = 1;
        if (f == 0) return xy;
        if (dx == mx && dy == my) return 1;
        xp = (dx > mx) ? 2 : 4;
        yp = (dy > my) ? 16 : 8;
        okx = (dx != mx);
        oky = (dy != my);
        if ((mx % 2 == 1) && (src == 3 || src == 4) && xp == 4) okx = 1'b0;
        if ((mx % 2 == 0) && src == 2) oky = 1'b0;
        if (!okx && !oky) return xy;
        if (!oky) return xp;
        if (!okx) return yp;
        fx = (xp == 2) ? f % 2 : (f / 2) % 2;
        fy = (yp == 8) ? (f / 4) % 2 : (f / 8) % 2;
        if (fx == 1 && fy == 0) return yp;
        return xp;
    endfunction

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R2: reset state with busy inputs
        buf_depth = 16'hFFFF;
        req_valid = 1'b1;
        repeat (3) @(negedge clk);
        chk("R2 cong_flag", int'(cong_flag), 0);
        chk("R2 route_valid", int'(route_valid), 0);
        chk("R2 route_port", int'(route_port), 0);
        req_valid = 1'b0;
        buf_depth = '0;
        rst_n = 1'b1;
        @(negedge clk);

        // R3: idle cycle gives no result
        dest_x = 3'd5;
        @(negedge clk);
        chk("R3 idle valid", int'(route_valid), 0);
        chk("R3 idle port", int'(route_port), 0);

        // R1: one buffer at a time, every depth, every threshold
        for (int th = 0; th < 16; th++) begin
            for (int b = 0; b < 4; b++) begin
                for (int d = 0; d < 16; d++) begin
                    thresh = 4'(th);
                    buf_depth = '0;
                    buf_depth[b*4 +: 4] = 4'(d);
                    @(negedge clk);
                    chk("R1 flag", int'(cong_flag), (d >= th) ? 1 : 0);
                end
            end
        end

        // R1: one-cycle lag of the flag
        thresh = 4'd6;
        buf_depth = 16'h0000;
        @(negedge clk);
        buf_depth = 16'h0600;
        #1 chk("R1 lag before edge", int'(cong_flag), 0);
        @(negedge clk);
        chk("R1 lag after edge", int'(cong_flag), 1);
        buf_depth = 16'h0500;
        #1 chk("R1 lag hold", int'(cong_flag), 1);
        @(negedge clk);
        chk("R1 drop", int'(cong_flag), 0);

        // R3..R10: routing sweep over two rows and all flag patterns
        req_valid = 1'b1;
        for (int mx = 0; mx < 8; mx++) begin
            for (int yi = 0; yi < 2; yi++) begin
                for (int dx = 0; dx < 8; dx++) begin
                    for (int dy = 0; dy < 8; dy++) begin
                        for (int s = 0; s < 5; s++) begin
                            for (int f = 0; f < 16; f++) begin
                                int my;
                                my = (yi == 0) ? 2 : 5;
                                my_x = 3'(mx); my_y = 3'(my);
                                dest_x = 3'(dx); dest_y = 3'(dy);
                                req_src = 3'(s); nbr_flag = 4'(f);
                                @(negedge clk);
                                chk("R3 valid", int'(route_valid), 1);
                                // R4 R5 R6 R7 R8 R9 R10
                                chk("R4-mode/R5/R6/R7/R8/R9/R10 port", int'(route_port),
                                    exp_route(mx, my, dx, dy, s, f));
                            end
                        end
                    end
                end
            end
        end

        // R8: unknown source codes behave as Local (no ban)
        my_x = 3'd2; my_y = 3'd2; dest_x = 3'd5; dest_y = 3'd6;
        nbr_flag = 4'b0001; req_src = 3'd6;
        @(negedge clk);
        chk("R8 src code 6 as Local", int'(route_port), 16);

        // R3: valid drops one cycle after request ends
        req_valid = 1'b0;
        @(negedge clk);
        chk("R3 valid drop", int'(route_valid), 0);
        chk("R3 port cleared", int'(route_port), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule